// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Pipeline

This block turns one calorimeter channel's stream of 7-bit digitized samples, one per bunch crossing, into an 8-bit compressed transverse-energy trigger primitive and a muon flag on every crossing. Each sample is first mapped to a linear energy through a loadable table, with the result clipped to the top code of the energy scale. The scale is 0.5 GeV per step, so 255 GeV is code 510. The energy of each crossing is then added to that of the crossing before it. A peak finder keeps the sum only at a local maximum and reports zero on every other crossing. The kept sum goes through a second loadable table that compresses it to eight bits.

Alongside the energy path, two one-bit tables indexed by the raw sample decide the muon flag. One table can set the flag. The other clears it when shower leakage could have set it falsely. The flag is delayed so that it meets the peak decision for the same crossing, and it is only reported on a peak.

Two controls act at the output stage. A bypass input sends the raw sample to the output in place of the primitive. A mask input forces both outputs to zero. All four tables are loaded through one write port, which takes a table select, an address and data.

Top module: `trig_prim_pipe`

## Requirements
- R1: While reset is held, tp_et and tp_mu are zero.
- R2: The linearization table holds 128 entries of 10 bits and is indexed by the sample. A stored value above ET_MAX (default 510) is used as ET_MAX.
- R3: The sum for crossing x is lin(x) + lin(x-1), saturating at 1023.
- R4: Crossing x is a peak when sum(x) > sum(x-1) and sum(x) >= sum(x+1). On a crossing that is not a peak, with mask and bypass low, tp_et and tp_mu are zero. Two adjacent crossings are never both peaks.
- R5: On a peak crossing, tp_et is the compression table entry (1024 entries of 8 bits) addressed by sum(x).
- R6: On a peak crossing, tp_mu = muon[s] AND NOT veto[s], where s is the sample of that crossing and both tables have 128 one-bit entries.
- R7: A sample captured at clock edge c gives its outputs after edge c+4, and mask and bypass are taken at that same edge c+4.
- R8: When bypass is high and mask is low at the output edge, tp_et is the raw sample of that crossing zero-extended to 8 bits, and tp_mu is 0.
- R9: When mask is high at the output edge, tp_et and tp_mu are zero after that edge, whatever bypass is.
- R10: A write takes wr_sel (0 linearization, 1 compression, 2 muon, 3 veto), the low address bits of wr_addr and the low data bits of wr_data (bit 0 for the one-bit tables). A lookup at the same edge as a write to the same entry returns the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one sample per edge |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| smp_in | input | 7 | Digitized sample |
| mask_in | input | 1 | Forces both outputs to zero |
| bypass_in | input | 1 | Selects the raw sample as output |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select: 0 lin, 1 compression, 2 muon, 3 veto |
| wr_addr | input | 10 | Table entry address |
| wr_data | input | 10 | Table entry data |
| tp_et | output | 8 | Compressed energy primitive |
| tp_mu | output | 1 | Muon flag |

## Verification
Every result of a sample captured at edge c is due after edge c+4. The peak decision also depends on the samples captured at c-2, c-1 and c+1, and mask and bypass are taken at c+4 itself. The bench keeps a ring of per-edge history: the linearized energy, the muon term and the raw sample, each computed from the bench's own table model at capture time. At each falling edge it checks the crossing captured four edges earlier. Table writes are applied to the model only after that edge's lookups have been recorded, so a lookup that collides with a write is predicted from the old content.

// File: rtl/tp_pkg.sv
package tp_pkg;
   typedef enum logic [1:0] {
      TBL_LIN  = 2'd0,
      TBL_CMP  = 2'd1,
      TBL_MU   = 2'd2,
      TBL_VETO = 2'd3
   } tbl_sel_e;

   // Edges from linear capture to the peak decision register.
   localparam int unsigned PEAK_STAGES = 3;
endpackage

// File: rtl/tp_lut.sv
module tp_lut #(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_geom
         $error("tp_lut: AW and DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Combinational read: a reader register sampling at the write edge sees old data.
   assign rdata = mem[raddr];
endmodule

// File: rtl/tp_peak.sv
module tp_peak #(
   parameter int unsigned ET_W = 10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ET_W-1:0] lin,
   output logic [ET_W-1:0] et_pk,
   output logic            pk_v
);
   logic [ET_W-1:0] lin_d;
   logic [ET_W-1:0] sum_q, sum_d, sum_dd;
   logic [ET_W:0]   wide_sum;
   logic [ET_W-1:0] sat_sum;
   logic            is_peak;

   assign wide_sum = {1'b0, lin} + {1'b0, lin_d};
   assign sat_sum  = wide_sum[ET_W] ? {ET_W{1'b1}} : wide_sum[ET_W-1:0];
   // sum_d is the candidate, sum_dd the crossing before, sum_q the one after.
   assign is_peak  = (sum_d > sum_dd) && (sum_d >= sum_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         lin_d  <= '0;
         sum_q  <= '0;
         sum_d  <= '0;
         sum_dd <= '0;
         et_pk  <= '0;
         pk_v   <= 1'b0;
      end else begin
         lin_d  <= lin;
         sum_q  <= sat_sum;
         sum_d  <= sum_q;
         sum_dd <= sum_d;
         pk_v   <= is_peak;
         et_pk  <= is_peak ? sum_d : '0;
      end
   end

   p_sum_ge_r3: assert property (@(posedge clk) disable iff (rst)
      sum_q >= lin_d)
      else $error("R3: saturating sum dropped below one addend");

   p_no_twin_peak_r4: assert property (@(posedge clk) disable iff (rst)
      pk_v |=> !pk_v)
      else $error("R4: two adjacent crossings flagged as peaks");
endmodule

// File: rtl/trig_prim_pipe.sv
module trig_prim_pipe
   import tp_pkg::*;
#(
   parameter int unsigned SMP_W  = 7,
   parameter int unsigned ET_W   = 10,
   parameter int unsigned TP_W   = 8,
   parameter int unsigned ET_MAX = 510
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [SMP_W-1:0] smp_in,
   input  logic            mask_in,
   input  logic            bypass_in,
   input  logic            wr_en,
   input  logic [1:0]      wr_sel,
   input  logic [ET_W-1:0] wr_addr,
   input  logic [ET_W-1:0] wr_data,
   output logic [TP_W-1:0] tp_et,
   output logic            tp_mu
);
   localparam int unsigned DLY_W = SMP_W + 1;
   localparam logic [ET_W-1:0] ET_CAP = ET_W'(ET_MAX);

   generate
      if (ET_MAX >= (1 << ET_W)) begin : g_bad_max
         $error("trig_prim_pipe: ET_MAX does not fit in ET_W");
      end
      if (ET_W < SMP_W || ET_W < TP_W) begin : g_bad_w
         $error("trig_prim_pipe: ET_W must cover sample and output widths");
      end
   endgenerate

   // Table write decode
   logic we_lin, we_cmp, we_mu, we_veto;
   assign we_lin  = wr_en && (wr_sel == TBL_LIN);
   assign we_cmp  = wr_en && (wr_sel == TBL_CMP);
   assign we_mu   = wr_en && (wr_sel == TBL_MU);
   assign we_veto = wr_en && (wr_sel == TBL_VETO);

   logic [ET_W-1:0] lin_rd;
   logic [TP_W-1:0] cmp_rd;
   logic            mu_rd, veto_rd;
   logic [ET_W-1:0] et_pk;
   logic            pk_v;

   tp_lut #(.AW(SMP_W), .DW(ET_W)) u_lin (
      .clk(clk), .we(we_lin), .waddr(wr_addr[SMP_W-1:0]), .wdata(wr_data),
      .raddr(smp_in), .rdata(lin_rd));

   tp_lut #(.AW(ET_W), .DW(TP_W)) u_cmp (
      .clk(clk), .we(we_cmp), .waddr(wr_addr), .wdata(wr_data[TP_W-1:0]),
      .raddr(et_pk), .rdata(cmp_rd));

   tp_lut #(.AW(SMP_W), .DW(1)) u_mu (
      .clk(clk), .we(we_mu), .waddr(wr_addr[SMP_W-1:0]), .wdata(wr_data[0]),
      .raddr(smp_in), .rdata(mu_rd));

   tp_lut #(.AW(SMP_W), .DW(1)) u_veto (
      .clk(clk), .we(we_veto), .waddr(wr_addr[SMP_W-1:0]), .wdata(wr_data[0]),
      .raddr(smp_in), .rdata(veto_rd));

   // Capture stage: linear energy clipped to the scale top, muon term, raw sample
   logic [ET_W-1:0]  lin_q;
   logic [DLY_W-1:0] side_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lin_q  <= '0;
         side_q <= '0;
      end else begin
         lin_q  <= (lin_rd > ET_CAP) ? ET_CAP : lin_rd;
         side_q <= {mu_rd & ~veto_rd, smp_in};
      end
   end

   tp_peak #(.ET_W(ET_W)) u_peak (
      .clk(clk), .rst(rst), .lin(lin_q), .et_pk(et_pk), .pk_v(pk_v));

   // Side data delay line, aligned with the peak decision
   logic [DLY_W-1:0] side_dl [PEAK_STAGES];

   always_ff @(posedge clk) begin
      if (rst) side_dl[0] <= '0;
      else     side_dl[0] <= side_q;
   end

   generate
      for (genvar i = 1; i < PEAK_STAGES; i++) begin : g_dly
         always_ff @(posedge clk) begin
            if (rst) side_dl[i] <= '0;
            else     side_dl[i] <= side_dl[i-1];
         end
      end
   endgenerate

   logic [SMP_W-1:0] raw_al;
   logic             mu_al;
   logic [TP_W-1:0]  byp_val;
   assign raw_al = side_dl[PEAK_STAGES-1][SMP_W-1:0];
   assign mu_al  = side_dl[PEAK_STAGES-1][SMP_W];

   generate
      if (TP_W >= SMP_W) begin : g_byp_ext
         assign byp_val = TP_W'(raw_al);
      end else begin : g_byp_trunc
         assign byp_val = raw_al[SMP_W-1 -: TP_W];
      end
   endgenerate

   // Output stage
   always_ff @(posedge clk) begin
      if (rst || mask_in) begin
         tp_et <= '0;
         tp_mu <= 1'b0;
      end else if (bypass_in) begin
         tp_et <= byp_val;
         tp_mu <= 1'b0;
      end else if (pk_v) begin
         tp_et <= cmp_rd;
         tp_mu <= mu_al;
      end else begin
         tp_et <= '0;
         tp_mu <= 1'b0;
      end
   end

   p_lin_clip_r2: assert property (@(posedge clk) disable iff (rst)
      lin_q <= ET_CAP)
      else $error("R2: linear energy above scale top");

   p_mask_zero_r9: assert property (@(posedge clk) disable iff (rst)
      mask_in |=> (tp_et == '0) && !tp_mu)
      else $error("R9: masked output not zero");

   p_bypass_nomu_r8: assert property (@(posedge clk) disable iff (rst)
      bypass_in && !mask_in |=> !tp_mu)
      else $error("R8: muon flag set in bypass");

   p_nopeak_zero_r4: assert property (@(posedge clk) disable iff (rst)
      !pk_v && !bypass_in && !mask_in |=> (tp_et == '0) && !tp_mu)
      else $error("R4: output on a non-peak crossing");
endmodule

// File: tb/test_trig_prim_pipe.sv
module test_trig_prim_pipe;
   localparam int CLK_P  = 25;
   localparam int ET_MAX = 510;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [6:0] smp = '0;
   logic       mask = 1'b0, byp = 1'b0, wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [9:0] wr_addr = '0, wr_data = '0;
   logic [7:0] tp_et;
   logic       tp_mu;

   trig_prim_pipe i_trig_prim_pipe (
      .clk(clk), .rst(rst), .smp_in(smp), .mask_in(mask), .bypass_in(byp),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .tp_et(tp_et), .tp_mu(tp_mu));

   always #(CLK_P/2) clk = ~clk;

   int checks = 0, errors = 0;
   int cyc = 0, chk_start = 1 << 30;
   string extra = "";

   // Bench model of the tables
   logic [9:0] m_lin [128];
   logic [7:0] m_cmp [1024];
   bit         m_mu  [128];
   bit         m_veto[128];

   // Per-edge history ring
   int  h_lin [16];
   bit  h_mu  [16];
   int  h_raw [16];
   bit  h_mask[16];
   bit  h_byp [16];

   function automatic int clip_lin(input logic [9:0] v);
      return (int'(v) > ET_MAX) ? ET_MAX : int'(v);
   endfunction

   function automatic int sat_sum(input int a, input int b);
      return (a + b > 1023) ? 1023 : a + b;
   endfunction

   task automatic check_out(input int n);
      int x, sx, sp, sn, e_et;
      bit e_mu;
      string tag;
      x  = n - 4;
      sx = sat_sum(h_lin[x & 15], h_lin[(x-1) & 15]);
      sp = sat_sum(h_lin[(x-1) & 15], h_lin[(x-2) & 15]);
      sn = sat_sum(h_lin[(x+1) & 15], h_lin[x & 15]);
      if (h_mask[n & 15]) begin
         e_et = 0; e_mu = 0; tag = "R9";
      end else if (h_byp[n & 15]) begin
         e_et = h_raw[x & 15]; e_mu = 0; tag = "R8";
      end else if (sx > sp && sx >= sn) begin
         e_et = int'(m_cmp[sx]); e_mu = h_mu[x & 15]; tag = "R5 R6 R7";
      end else begin
         e_et = 0; e_mu = 0; tag = "R4";
      end
      checks++;
      if (int'(tp_et) != e_et || tp_mu != e_mu) begin
         errors++;
         $display("FAIL %s %s: et=%0d mu=%0d expected et=%0d mu=%0d",
                  tag, extra, tp_et, tp_mu, e_et, e_mu);
      end
   endtask

   // One crossing: record the edge just passed, check, commit writes, drive next.
   task automatic step(input logic [6:0] s, input bit m, input bit b, input bit we,
                       input logic [1:0] sel, input logic [9:0] a, input logic [9:0] d);
      @(negedge clk);
      cyc++;
      h_lin [cyc & 15] = clip_lin(m_lin[smp]);
      h_mu  [cyc & 15] = m_mu[smp] & ~m_veto[smp];
      h_raw [cyc & 15] = int'(smp);
      h_mask[cyc & 15] = mask;
      h_byp [cyc & 15] = byp;
      if (cyc >= chk_start) check_out(cyc);
      if (wr_en) begin
         case (wr_sel)
            2'd0: m_lin[wr_addr[6:0]] = wr_data;
            2'd1: m_cmp[wr_addr] = wr_data[7:0];
            2'd2: m_mu[wr_addr[6:0]] = wr_data[0];
            default: m_veto[wr_addr[6:0]] = wr_data[0];
         endcase
      end
      smp = s; mask = m; byp = b;
      wr_en = we; wr_sel = sel; wr_addr = a; wr_data = d;
   endtask

   task automatic idle(input logic [6:0] s);
      step(s, 1'b0, 1'b0, 1'b0, 2'd0, 10'd0, 10'd0);
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      // Load all tables while in reset (R10 codes: 0 lin, 1 cmp, 2 mu, 3 veto)
      for (int i = 0; i < 128; i++)
         step(7'd0, 1'b0, 1'b0, 1'b1, 2'd0, 10'(i), 10'($urandom % 1024));
      for (int i = 0; i < 1024; i++)
         step(7'd0, 1'b0, 1'b0, 1'b1, 2'd1, 10'(i), 10'($urandom % 256));
      for (int i = 0; i < 128; i++)
         step(7'd0, 1'b0, 1'b0, 1'b1, 2'd2, 10'(i), 10'($urandom % 2));
      for (int i = 0; i < 128; i++)
         step(7'd0, 1'b0, 1'b0, 1'b1, 2'd3, 10'(i), 10'($urandom % 4 == 0));
      idle(7'd0);
      // R1: outputs zero under reset
      checks++;
      if (tp_et != 8'd0 || tp_mu != 1'b0) begin
         errors++;
         $display("FAIL R1: et=%0d mu=%0d expected et=0 mu=0", tp_et, tp_mu);
      end
      rst = 1'b0;
      chk_start = cyc + 8;

      // Random crossings with occasional mask, bypass and table writes
      for (int k = 0; k < 1500; k++)
         step(7'($urandom % 128), ($urandom % 8 == 0), ($urandom % 8 == 0),
              ($urandom % 4 == 0), 2'($urandom % 4), 10'($urandom % 1024),
              10'($urandom % 1024));

      // R2 R3: clipped linear value summed to the peak
      extra = "R2 R3";
      step(7'd0, 1'b0, 1'b0, 1'b1, 2'd0, 10'd1, 10'd1000);
      step(7'd0, 1'b0, 1'b0, 1'b1, 2'd0, 10'd0, 10'd0);
      step(7'd0, 1'b0, 1'b0, 1'b1, 2'd1, 10'd1020, 10'hEE);
      step(7'd0, 1'b0, 1'b0, 1'b1, 2'd1, 10'd1023, 10'h11);
      for (int k = 0; k < 4; k++) idle(7'd0);
      idle(7'd1); idle(7'd1);
      for (int k = 0; k < 8; k++) idle(7'd0);

      // R10: lookup colliding with a write to the same entry sees old content
      extra = "R10";
      step(7'd0, 1'b0, 1'b0, 1'b1, 2'd0, 10'd5, 10'd100);
      step(7'd0, 1'b0, 1'b0, 1'b1, 2'd2, 10'd5, 10'd1);
      step(7'd0, 1'b0, 1'b0, 1'b1, 2'd3, 10'd5, 10'd0);
      for (int k = 0; k < 4; k++) idle(7'd0);
      idle(7'd5);
      step(7'd5, 1'b0, 1'b0, 1'b1, 2'd0, 10'd5, 10'd300);
      step(7'd5, 1'b0, 1'b0, 1'b1, 2'd3, 10'd5, 10'd1);
      for (int k = 0; k < 8; k++) idle(7'd0);

      // R8 R9: mask overriding bypass, then bypass alone
      extra = "R8 R9";
      for (int k = 0; k < 6; k++) step(7'd127, 1'b1, 1'b1, 1'b0, 2'd0, 10'd0, 10'd0);
      for (int k = 0; k < 6; k++) step(7'd127, 1'b0, 1'b1, 1'b0, 2'd0, 10'd0, 10'd0);
      for (int k = 0; k < 6; k++) idle(7'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule